// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block sits between a single processor port and a word-addressed main-memory port. It holds a small direct-mapped set of lines, each several words long. A build-time parameter fixes how writes are treated. In write-back mode, writes stay in the cache, lines turn dirty, and missing lines are allocated on a write. In write-through mode, every write goes straight to memory and a write miss leaves the cache untouched.

The processor presents a request and holds it until the cache raises its ready output. Hits complete in the cycle they are presented. Misses, evictions of modified lines and write-through stores drive a request/acknowledge memory handshake that moves one word per acknowledge. Ready stays low for as long as that handshake is in progress. A separate invalidate-by-address input lets the surrounding system drop a line after another bus master, such as a DMA engine, has changed memory behind the cache. It is honoured while the cache is idle.

Top module: `wpc_cache_top`

## Requirements
- R1: A read whose line is present and whose tag matches returns the cached word with ready high in the same cycle, and no memory transfer takes place.
- R2: A word address splits into offset (bits 1:0), line index (bits 5:2) and tag (the bits above). A read miss fetches all four words of the line, in ascending order from offset 0, as reads (mem_we low), then installs the line and returns the requested word.
- R3: In write-back mode, a write hit updates only the cached word, marks the line dirty and completes with no memory transfer. Memory keeps its old value.
- R4: In write-back mode, replacing a dirty line first writes its four words to the old line address in ascending order, and then fills the new line.
- R5: In write-back mode, a write miss fills the line from memory and then applies the write as a hit. No memory write occurs if the displaced line is clean.
- R6: In write-through mode, every write makes exactly one memory write of the data at its own address. On a hit, the cached copy is also updated, so a following read of that address returns the new data without a memory transfer.
- R7: In write-through mode, a write miss leaves the cache unchanged. The line resident at that index still hits, and a later read of the written address misses and fetches.
- R8: In write-through mode, lines are never dirty, and replacing a line causes no memory write.
- R9: While mem_req is high, cpu_ready is low. mem_addr, mem_we and mem_wdata hold steady until mem_ack is seen.
- R10: An idle-time invalidate whose address matches a clean resident line makes that line invalid from the next cycle, so the next read refetches from memory. An invalidate whose tag does not match changes nothing.
- R11: In write-back mode, invalidating a dirty line first writes its four words back to memory, and then invalidates the line.
- R12: After reset, every line is invalid, cpu_ready is high and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on a read |
| cpu_ready | output | 1 | Request completes this cycle / cache not busy |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | One word transferred this cycle |
| inv_req | input | 1 | Invalidate request (idle cache) |
| inv_addr | input | ADDR_W | Address whose line is invalidated |

## Verification
The bench runs one instance of each write policy against a memory model that logs every word transferred. The log exposes several likely faults:
- A cache that skips the write-back before a fill loses the dirty word from memory. The log then shows reads where writes were expected.
- A write-through cache that allocates on a write miss would evict the resident line. The following read of that line then issues a fetch.
- Invalidating a dirty line without writing it back leaves memory stale. The refetch then returns the old word.
- A non-matching invalidate that clears the line turns a later hit into a fetch.

The stale-read-then-invalidate sequence confirms that a memory change made outside the cache only becomes visible after the invalidate.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        L_INV   = 2'd0,
        L_VAL   = 2'd1,
        L_DIRTY = 2'd2
    } line_st_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WBACK = 3'd1,
        S_FILL  = 3'd2,
        S_WTHRU = 3'd3,
        S_RESP  = 3'd4
    } ctl_st_t;

    function automatic logic line_present(line_st_t s);
        return s != L_INV;
    endfunction

endpackage

// File: rtl/wpc_store.sv
module wpc_store
    import wpc_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [OFF_W-1:0]  lk_off,
    output logic [TAG_W-1:0]  lk_tag,
    output line_st_t          lk_st,
    output logic [DATA_W-1:0] lk_word,
    input  logic [IDX_W-1:0]  ax_idx,
    input  logic [OFF_W-1:0]  ax_off,
    output logic [DATA_W-1:0] ax_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mt_en,
    input  logic [IDX_W-1:0]  mt_idx,
    input  logic [TAG_W-1:0]  mt_tag,
    input  line_st_t          mt_st
);

    logic [DATA_W-1:0] data_q [LINES][WORDS];
    logic [TAG_W-1:0]  tag_q  [LINES];
    line_st_t          st_q   [LINES];

    assign lk_tag  = tag_q[lk_idx];
    assign lk_st   = st_q[lk_idx];
    assign lk_word = data_q[lk_idx][lk_off];
    assign ax_word = data_q[ax_idx][ax_off];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx][wr_off] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= L_INV;
                tag_q[i] <= '0;
            end
        end else if (mt_en) begin
            st_q[mt_idx]  <= mt_st;
            tag_q[mt_idx] <= mt_tag;
        end
    end

    // R3 / R6: a word write is visible at the written location one cycle later
    a_r3_word_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> data_q[$past(wr_idx)][$past(wr_off)] == $past(wr_data));

    // R10: a line-state update takes effect in the next cycle
    a_r10_state_write_lands: assert property (@(posedge clk) disable iff (rst)
        mt_en |=> st_q[$past(mt_idx)] == $past(mt_st));

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int WORDS      = 4,
    parameter bit WRITE_BACK = 1'b1,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [OFF_W-1:0]  lk_off,
    input  logic [TAG_W-1:0]  lk_tag_i,
    input  line_st_t          lk_st_i,
    input  logic [DATA_W-1:0] lk_word_i,
    output logic [IDX_W-1:0]  ax_idx,
    output logic [OFF_W-1:0]  ax_off,
    input  logic [DATA_W-1:0] ax_word_i,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              mt_en,
    output logic [IDX_W-1:0]  mt_idx,
    output logic [TAG_W-1:0]  mt_tag,
    output line_st_t          mt_st
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } waddr_t;

    waddr_t            cpu_a, inv_a, pend_q;
    ctl_st_t           st_q, st_d;
    logic [OFF_W-1:0]  cnt_q;
    logic [TAG_W-1:0]  vtag_q;
    logic [DATA_W-1:0] wdat_q;
    logic              inv_wb_q;

    assign cpu_a = waddr_t'(cpu_addr);
    assign inv_a = waddr_t'(inv_addr);

    logic idle, xfer, last_beat, present;
    logic cpu_hit, inv_hit, pend_hit, need_mem, victim_dirty;

    assign idle      = (st_q == S_IDLE);
    assign xfer      = mem_req && mem_ack;
    assign last_beat = (cnt_q == OFF_W'(WORDS - 1));

    // one lookup port: invalidate first, then processor, else the pending line
    assign lk_idx = idle ? (inv_req ? inv_a.idx : cpu_a.idx) : pend_q.idx;
    assign lk_off = idle ? cpu_a.off : pend_q.off;
    assign ax_idx = pend_q.idx;
    assign ax_off = cnt_q;

    assign present      = line_present(lk_st_i);
    assign cpu_hit      = present && (lk_tag_i == cpu_a.tag);
    assign inv_hit      = present && (lk_tag_i == inv_a.tag);
    assign pend_hit     = present && (lk_tag_i == pend_q.tag);
    assign need_mem     = !cpu_hit || (!WRITE_BACK && cpu_we);
    assign victim_dirty = WRITE_BACK && (lk_st_i == L_DIRTY);

    assign cpu_ready = (idle && !inv_req && !(cpu_req && need_mem)) || (st_q == S_RESP);
    assign cpu_rdata = lk_word_i;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vtag_q, pend_q.idx, cnt_q};
                mem_wdata = ax_word_i;
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {pend_q.tag, pend_q.idx, cnt_q};
            end
            S_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pend_q;
                mem_wdata = wdat_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_idx  = pend_q.idx;
        wr_off  = cnt_q;
        wr_data = mem_rdata;
        mt_en   = 1'b0;
        mt_idx  = pend_q.idx;
        mt_tag  = pend_q.tag;
        mt_st   = L_VAL;
        unique case (st_q)
            S_IDLE: begin
                if (inv_req) begin
                    if (inv_hit && victim_dirty) begin
                        st_d = S_WBACK;
                    end else if (inv_hit) begin
                        mt_en  = 1'b1;
                        mt_idx = inv_a.idx;
                        mt_tag = lk_tag_i;
                        mt_st  = L_INV;
                    end
                end else if (cpu_req) begin
                    if (!need_mem) begin
                        if (cpu_we) begin
                            wr_en   = 1'b1;
                            wr_idx  = cpu_a.idx;
                            wr_off  = cpu_a.off;
                            wr_data = cpu_wdata;
                            mt_en   = 1'b1;
                            mt_idx  = cpu_a.idx;
                            mt_tag  = cpu_a.tag;
                            mt_st   = L_DIRTY;
                        end
                    end else if (!WRITE_BACK && cpu_we) begin
                        st_d = S_WTHRU;
                    end else begin
                        st_d = victim_dirty ? S_WBACK : S_FILL;
                    end
                end
            end
            S_WBACK: begin
                if (xfer && last_beat) begin
                    st_d = inv_wb_q ? S_IDLE : S_FILL;
                    if (inv_wb_q) begin
                        mt_en  = 1'b1;
                        mt_tag = vtag_q;
                        mt_st  = L_INV;
                    end
                end
            end
            S_FILL: begin
                if (xfer) begin
                    wr_en = 1'b1;
                    if (last_beat) begin
                        mt_en = 1'b1;
                        st_d  = S_IDLE;
                    end
                end
            end
            S_WTHRU: begin
                if (xfer) begin
                    if (pend_hit) begin
                        wr_en   = 1'b1;
                        wr_off  = pend_q.off;
                        wr_data = wdat_q;
                    end
                    st_d = S_RESP;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            cnt_q    <= '0;
            pend_q   <= '0;
            vtag_q   <= '0;
            wdat_q   <= '0;
            inv_wb_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (idle && st_d != S_IDLE) begin
                pend_q   <= inv_req ? inv_a : cpu_a;
                vtag_q   <= lk_tag_i;
                wdat_q   <= cpu_wdata;
                inv_wb_q <= inv_req;
                cnt_q    <= '0;
            end else if (xfer && (st_q == S_WBACK || st_q == S_FILL)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9: processor stalled during every memory transaction
    a_r9_stall_while_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    // R9: request fields hold until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R12: idle after reset with no memory activity
    a_r12_quiet_reset: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && st_q == S_IDLE));

    generate
        if (!WRITE_BACK) begin : g_wt_chk
            // R8: write-through lines never become dirty
            a_r8_no_dirty_line: assert property (@(posedge clk) disable iff (rst)
                lk_st_i != L_DIRTY);
        end
    endgenerate

endmodule

// File: rtl/wpc_cache_top.sv
module wpc_cache_top
    import wpc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int WORDS      = 4,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx, ax_idx, wr_idx, mt_idx;
    logic [OFF_W-1:0]  lk_off, ax_off, wr_off;
    logic [TAG_W-1:0]  lk_tag, mt_tag;
    line_st_t          lk_st, mt_st;
    logic [DATA_W-1:0] lk_word, ax_word, wr_data;
    logic              wr_en, mt_en;

    wpc_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) store_i (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag(lk_tag), .lk_st(lk_st), .lk_word(lk_word),
        .ax_idx(ax_idx), .ax_off(ax_off), .ax_word(ax_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
        .mt_en(mt_en), .mt_idx(mt_idx), .mt_tag(mt_tag), .mt_st(mt_st)
    );

    wpc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
        .WRITE_BACK(WRITE_BACK)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .inv_req(inv_req), .inv_addr(inv_addr),
        .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag_i(lk_tag), .lk_st_i(lk_st),
        .lk_word_i(lk_word),
        .ax_idx(ax_idx), .ax_off(ax_off), .ax_word_i(ax_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
        .mt_en(mt_en), .mt_idx(mt_idx), .mt_tag(mt_tag), .mt_st(mt_st)
    );

endmodule

// File: tb/wpc_cache_top_tb_top.sv
`timescale 1ns/1ps
module wpc_cache_top_tb_top;

    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          cpu_req [2];
    logic          cpu_we [2];
    logic [AW-1:0] cpu_addr [2];
    logic [DW-1:0] cpu_wdata [2];
    logic [DW-1:0] cpu_rdata [2];
    logic          cpu_ready [2];
    logic          mem_req [2];
    logic          mem_we [2];
    logic [AW-1:0] mem_addr [2];
    logic [DW-1:0] mem_wdata [2];
    logic [DW-1:0] mem_rdata [2];
    logic          mem_ack [2];
    logic          inv_req [2];
    logic [AW-1:0] inv_addr [2];

    logic [DW-1:0] bmem [2][1024];
    logic          lg_we [2][512];
    logic [AW-1:0] lg_addr [2][512];
    logic [DW-1:0] lg_dat [2][512];
    int            lg_n [2];
    int            n_chk = 0;
    int            n_bad = 0;
    int            r9_bad = 0;

    // instance 0: write-back, instance 1: write-through
    for (genvar g = 0; g < 2; g++) begin : g_dut
        wpc_cache_top #(.ADDR_W(AW), .DATA_W(DW), .WRITE_BACK(g == 0)) dut_i (
            .clk(clk), .rst(rst),
            .cpu_req(cpu_req[g]), .cpu_we(cpu_we[g]), .cpu_addr(cpu_addr[g]),
            .cpu_wdata(cpu_wdata[g]), .cpu_rdata(cpu_rdata[g]), .cpu_ready(cpu_ready[g]),
            .mem_req(mem_req[g]), .mem_we(mem_we[g]), .mem_addr(mem_addr[g]),
            .mem_wdata(mem_wdata[g]), .mem_rdata(mem_rdata[g]), .mem_ack(mem_ack[g]),
            .inv_req(inv_req[g]), .inv_addr(inv_addr[g])
        );

        assign mem_rdata[g] = bmem[g][mem_addr[g]];

        always @(posedge clk) begin
            if (rst) mem_ack[g] <= 1'b0;
            else     mem_ack[g] <= mem_req[g] && !mem_ack[g];
            if (!rst && mem_req[g] && mem_ack[g]) begin
                if (lg_n[g] < 512) begin
                    lg_we[g][lg_n[g]]   = mem_we[g];
                    lg_addr[g][lg_n[g]] = mem_addr[g];
                    lg_dat[g][lg_n[g]]  = mem_we[g] ? mem_wdata[g] : mem_rdata[g];
                end
                lg_n[g] = lg_n[g] + 1;
                if (mem_we[g]) bmem[g][mem_addr[g]] <= mem_wdata[g];
            end
        end

        always @(negedge clk) begin
            if (!rst && mem_req[g] && cpu_ready[g]) r9_bad = r9_bad + 1;
        end
    end

    task automatic check(input string r, input string what, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic access(input int m, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd,
                          output int cyc);
        @(negedge clk);
        cpu_req[m] = 1'b1; cpu_we[m] = we; cpu_addr[m] = a; cpu_wdata[m] = d;
        cyc = 0;
        #0.1;
        while (!cpu_ready[m] && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata[m];
        @(posedge clk);
        #0.5 cpu_req[m] = 1'b0;
        cpu_we[m] = 1'b0;
    endtask

    task automatic invalidate(input int m, input logic [AW-1:0] a);
        @(negedge clk);
        inv_req[m] = 1'b1; inv_addr[m] = a;
        @(posedge clk);
        #0.5 inv_req[m] = 1'b0;
        repeat (16) @(posedge clk);
        #0.5;
    endtask

    task automatic check_beats(input int m, input int st, input int first, input int n,
                               input bit we, input logic [AW-1:0] base, input string r);
        for (int k = 0; k < n; k++) begin
            check(r, "beat direction", DW'(lg_we[m][st+first+k]), DW'(we));
            check(r, "beat address", DW'(lg_addr[m][st+first+k]), DW'(base + AW'(k)));
        end
    endtask

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hA000_0000 | a;
    endfunction

    task automatic t_reset();
        for (int m = 0; m < 2; m++) begin
            check("R12", "ready after reset", DW'(cpu_ready[m]), 1);
            check("R12", "mem_req after reset", DW'(mem_req[m]), 0);
        end
    endtask

    task automatic t_read_miss(input int m);
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[m];
        access(m, 1'b0, 10'h013, '0, rd, cyc);
        check("R2", "miss data", rd, init_val('h013));
        check("R2", "fill beat count", DW'(lg_n[m] - st), 4);
        check_beats(m, st, 0, 4, 1'b0, 10'h010, "R2");
        check("R12", "first access missed", DW'(cyc > 0), 1);
    endtask

    task automatic t_read_hit(input int m);
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[m];
        access(m, 1'b0, 10'h011, '0, rd, cyc);
        check("R1", "hit data", rd, init_val('h011));
        check("R1", "hit latency", DW'(cyc), 0);
        check("R1", "hit memory beats", DW'(lg_n[m] - st), 0);
    endtask

    task automatic t_wb_write_hit();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[0];
        access(0, 1'b1, 10'h012, 32'hDEAD_0001, rd, cyc);
        check("R3", "write hit latency", DW'(cyc), 0);
        access(0, 1'b0, 10'h012, '0, rd, cyc);
        check("R3", "read back", rd, 32'hDEAD_0001);
        check("R3", "memory beats", DW'(lg_n[0] - st), 0);
        check("R3", "memory untouched", bmem[0]['h012], init_val('h012));
    endtask

    task automatic t_wb_evict();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[0];
        access(0, 1'b0, 10'h052, '0, rd, cyc);
        check("R4", "new line data", rd, init_val('h052));
        check("R4", "beat count", DW'(lg_n[0] - st), 8);
        check_beats(0, st, 0, 4, 1'b1, 10'h010, "R4");
        check_beats(0, st, 4, 4, 1'b0, 10'h050, "R4");
        check("R4", "written-back dirty word", lg_dat[0][st+2], 32'hDEAD_0001);
        check("R4", "written-back clean word", lg_dat[0][st], init_val('h010));
        check("R4", "memory updated", bmem[0]['h012], 32'hDEAD_0001);
    endtask

    task automatic t_wb_write_miss();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[0];
        access(0, 1'b1, 10'h0A1, 32'hBEEF_0002, rd, cyc);
        check("R5", "allocate beat count", DW'(lg_n[0] - st), 4);
        check_beats(0, st, 0, 4, 1'b0, 10'h0A0, "R5");
        st = lg_n[0];
        access(0, 1'b0, 10'h0A1, '0, rd, cyc);
        check("R5", "written word cached", rd, 32'hBEEF_0002);
        check("R5", "read is a hit", DW'(lg_n[0] - st), 0);
        check("R5", "memory untouched", bmem[0]['h0A1], init_val('h0A1));
    endtask

    task automatic t_wb_inv_dirty();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[0];
        invalidate(0, 10'h0A0);
        check("R11", "write-back beats", DW'(lg_n[0] - st), 4);
        check_beats(0, st, 0, 4, 1'b1, 10'h0A0, "R11");
        check("R11", "memory holds dirty word", bmem[0]['h0A1], 32'hBEEF_0002);
        st = lg_n[0];
        access(0, 1'b0, 10'h0A1, '0, rd, cyc);
        check("R11", "line was invalidated", DW'(lg_n[0] - st), 4);
        check("R11", "refetched data", rd, 32'hBEEF_0002);
    endtask

    task automatic t_inv_clean(input int m, input logic [AW-1:0] a, input logic [DW-1:0] stale,
                               input logic [DW-1:0] fresh, input logic [AW-1:0] other);
        logic [DW-1:0] rd; int cyc; int st;
        bmem[m][a] = fresh;
        st = lg_n[m];
        invalidate(m, other);
        access(m, 1'b0, a, '0, rd, cyc);
        check("R10", "stale copy still hit", rd, stale);
        check("R10", "non-matching invalidate ignored", DW'(lg_n[m] - st), 0);
        invalidate(m, a);
        check("R10", "clean invalidate no beats", DW'(lg_n[m] - st), 0);
        access(m, 1'b0, a, '0, rd, cyc);
        check("R10", "refetch beats", DW'(lg_n[m] - st), 4);
        check("R10", "fresh data", rd, fresh);
    endtask

    task automatic t_wt_write_hit();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[1];
        access(1, 1'b1, 10'h012, 32'hCAFE_0003, rd, cyc);
        check("R6", "one memory beat", DW'(lg_n[1] - st), 1);
        check_beats(1, st, 0, 1, 1'b1, 10'h012, "R6");
        check("R6", "memory data", bmem[1]['h012], 32'hCAFE_0003);
        st = lg_n[1];
        access(1, 1'b0, 10'h012, '0, rd, cyc);
        check("R6", "cache updated", rd, 32'hCAFE_0003);
        check("R6", "read is a hit", DW'(lg_n[1] - st), 0);
    endtask

    task automatic t_wt_write_miss();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[1];
        access(1, 1'b1, 10'h0A1, 32'hBEEF_0004, rd, cyc);
        access(1, 1'b1, 10'h052, 32'h0000_5555, rd, cyc);
        check("R7", "one beat per write", DW'(lg_n[1] - st), 2);
        check_beats(1, st, 0, 1, 1'b1, 10'h0A1, "R7");
        check_beats(1, st, 1, 1, 1'b1, 10'h052, "R7");
        check("R7", "memory data", bmem[1]['h0A1], 32'hBEEF_0004);
        st = lg_n[1];
        access(1, 1'b0, 10'h011, '0, rd, cyc);
        check("R7", "resident line kept", DW'(lg_n[1] - st), 0);
        check("R7", "resident data", rd, init_val('h011));
        access(1, 1'b0, 10'h052, '0, rd, cyc);
        check("R7", "written line not allocated", DW'(lg_n[1] - st), 4);
        check("R7", "fetched data", rd, 32'h0000_5555);
    endtask

    task automatic t_wt_clean_evict();
        logic [DW-1:0] rd; int cyc; int st;
        st = lg_n[1];
        access(1, 1'b0, 10'h012, '0, rd, cyc);
        check("R8", "evict beat count", DW'(lg_n[1] - st), 4);
        check_beats(1, st, 0, 4, 1'b0, 10'h010, "R8");
        check("R8", "data", rd, 32'hCAFE_0003);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            cpu_req[m] = 0; cpu_we[m] = 0; cpu_addr[m] = '0; cpu_wdata[m] = '0;
            inv_req[m] = 0; inv_addr[m] = '0; lg_n[m] = 0;
            for (int a = 0; a < 1024; a++) bmem[m][a] = init_val(a);
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #0.5;
        t_reset();
        for (int m = 0; m < 2; m++) begin
            t_read_miss(m);
            t_read_hit(m);
        end
        t_wb_write_hit();
        t_wb_evict();
        t_wb_write_miss();
        t_wb_inv_dirty();
        t_inv_clean(0, 10'h052, init_val('h052), 32'h1234_5678, 10'h1D2);
        t_wt_write_hit();
        t_wt_write_miss();
        t_wt_clean_evict();
        t_inv_clean(1, 10'h013, init_val('h013), 32'h0000_0077, 10'h1D3);
        check("R9", "ready low during memory activity", DW'(r9_bad), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule